// File: doc/BRIEF.md
# Privileged-Mode Exception Dispatch Unit

This block decides, once per clock, whether the processor leaves its current instruction stream for privileged handler code. A synchronous exception is presented with a cause code and an 8-bit code argument. Four level-sensitive interrupt lines (device, timer, inter-processor, machine check) are filtered against the current interrupt priority level (IPL). The winner is turned into an entry offset inside the privileged code region. One cycle later the unit raises a single-cycle redirect with the new PC (region base plus offset) and the saved return address, and it switches into privileged mode.

The exception port carries no back-pressure. `exc_valid` is sampled on every rising edge and each valid request is taken in that cycle. The caller holds a request for exactly one cycle per event. Interrupt lines are plain levels, and the block acts on them only when no exception is presented. Returning from privileged mode is not part of this block; only reset clears the mode.

Top module: `exc_dispatch`

## Requirements
- R1: Cause codes 0 to 9 (0 reset, 1 machine check, 2 inter-processor, 3 clock, 4 device, 5 memory fault, 6 unaligned, 7 illegal opcode, 8 arithmetic, 9 FP disabled) vector to offset cause*0x80.
- R2: Cause 10 (call) with code bit 7 clear vectors to offset 0x1000 + code*64.
- R3: Cause 10 with code bit 7 set vectors to offset 0x2000 + (code-0x80)*64.
- R4: One cycle after a dispatch is accepted, `redirect` is high for that one cycle, `new_pc` equals base plus offset, and `priv_mode` is 1.
- R5: `exc_addr` equals the PC sampled with the dispatch, with bit 0 replaced by OR of that PC bit and the privileged-mode flag held at that time.
- R6: Interrupt line bit 0 (device) is accepted at IPL 0..3, bit 1 (timer) at IPL <= 4, bit 2 (inter-processor) at IPL <= 5, bit 3 (machine check) at IPL <= 6. None is accepted at IPL 7.
- R7: Among accepted lines, the priority is machine check, then inter-processor, then timer, then device. Each vectors as its cause in R1.
- R8: While `priv_mode` is 1, no interrupt is taken.
- R9: An exception presented in the same cycle as accepted interrupts wins.
- R10: `err_code` takes the code input on an exception and becomes 0 on an interrupt.
- R11: Cause codes 11..15 give a one-cycle `cause_err` pulse and no redirect. `new_pc`, `exc_addr`, `err_code` and `priv_mode` keep their values.
- R12: After reset, `redirect`, `cause_err` and `priv_mode` are 0, and `new_pc`, `exc_addr` and `err_code` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception request, taken in the cycle it is high |
| exc_cause | input | 4 | Cause code (R1, R2, R11) |
| exc_code | input | 8 | Call number / error code |
| irq_lines | input | 4 | Bit 0 device, 1 timer, 2 inter-processor, 3 machine check |
| ipl | input | 3 | Current interrupt priority level |
| pc_in | input | 64 | PC of the interrupted instruction stream |
| priv_base | input | 64 | Base of the privileged code region |
| redirect | output | 1 | One-cycle pulse: fetch from new_pc |
| new_pc | output | 64 | Handler entry address |
| exc_addr | output | 64 | Saved return address with mode in bit 0 |
| err_code | output | 8 | Error code seen by the handler |
| priv_mode | output | 1 | Privileged-mode flag |
| cause_err | output | 1 | One-cycle pulse on an unknown cause |

## Verification
Every result is registered, so all outputs of a dispatch are due exactly one rising edge after the inputs were sampled. The bench drives inputs on the falling edge and compares `redirect`, `new_pc`, `exc_addr`, `err_code`, `priv_mode` and `cause_err` on the next falling edge, after exactly one rising edge. For an unknown cause, the same sample confirms that the held outputs match the values predicted for the previous dispatch.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;
  localparam int CAUSE_W   = 4;
  localparam int CODE_W    = 8;
  localparam int IRQ_N     = 4;
  localparam int IPL_W     = 3;
  localparam int OFF_W     = 14;
  localparam int FIX_LAST  = 9;
  localparam int VEC_SHIFT = 7;
  localparam int CALL_SHIFT = 6;
  localparam int IRQ_BASE_IPL = 3;

  typedef enum logic [CAUSE_W-1:0] {
    C_RESET = 4'd0, C_MCHK  = 4'd1, C_IPI    = 4'd2, C_CLOCK = 4'd3,
    C_DEV   = 4'd4, C_MMF   = 4'd5, C_UNALGN = 4'd6, C_ILLOP = 4'd7,
    C_ARITH = 4'd8, C_FPDIS = 4'd9, C_CALL   = 4'd10
  } cause_e;

  localparam logic [OFF_W-1:0] PRIV_CALL_BASE   = 14'h1000;
  localparam logic [OFF_W-1:0] UNPRIV_CALL_BASE = 14'h2000;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import exc_dispatch_pkg::*;
(
  input  logic [IRQ_N-1:0]   lines,
  input  logic [IPL_W-1:0]   level,
  input  logic               blocked,
  output logic               take,
  output logic [CAUSE_W-1:0] cause
);
  logic [IRQ_N-1:0] accepted;

  generate
    for (genvar i = 0; i < IRQ_N; i++) begin : g_gate
      localparam int LIMIT = IRQ_BASE_IPL + i;
      assign accepted[i] = lines[i] && (int'(level) <= LIMIT) && !blocked;
    end
  endgenerate

  always_comb begin
    take  = 1'b0;
    cause = '0;
    for (int i = 0; i < IRQ_N; i++) begin
      if (accepted[i]) begin
        take  = 1'b1;
        cause = CAUSE_W'(int'(C_DEV) - i);
      end
    end
  end
endmodule

// File: rtl/vector_calc.sv
module vector_calc
  import exc_dispatch_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause,
  input  logic [CODE_W-1:0]  code,
  output logic               known,
  output logic [OFF_W-1:0]   offset
);
  logic [CODE_W-2:0] slot;

  assign slot = code[CODE_W-2:0];

  always_comb begin
    known  = 1'b1;
    offset = '0;
    if (int'(cause) <= FIX_LAST) begin
      offset = OFF_W'(cause) << VEC_SHIFT;
    end else if (cause == C_CALL) begin
      offset = (code[CODE_W-1] ? UNPRIV_CALL_BASE : PRIV_CALL_BASE)
             + (OFF_W'(slot) << CALL_SHIFT);
    end else begin
      known = 1'b0;
    end
  end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_dispatch_pkg::*;
#(
  parameter int PC_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic [CODE_W-1:0]  exc_code,
  input  logic [IRQ_N-1:0]   irq_lines,
  input  logic [IPL_W-1:0]   ipl,
  input  logic [PC_W-1:0]    pc_in,
  input  logic [PC_W-1:0]    priv_base,
  output logic               redirect,
  output logic [PC_W-1:0]    new_pc,
  output logic [PC_W-1:0]    exc_addr,
  output logic [CODE_W-1:0]  err_code,
  output logic               priv_mode,
  output logic               cause_err
);
  logic               irq_take;
  logic [CAUSE_W-1:0] irq_cause;
  logic [CAUSE_W-1:0] sel_cause;
  logic [CODE_W-1:0]  sel_code;
  logic               vec_known;
  logic [OFF_W-1:0]   vec_off;
  logic               go;
  logic               bad;

  irq_pick u_pick (
    .lines   (irq_lines),
    .level   (ipl),
    .blocked (priv_mode),
    .take    (irq_take),
    .cause   (irq_cause)
  );

  assign sel_cause = exc_valid ? exc_cause : irq_cause;
  assign sel_code  = exc_valid ? exc_code  : '0;

  vector_calc u_vec (
    .cause  (sel_cause),
    .code   (sel_code),
    .known  (vec_known),
    .offset (vec_off)
  );

  assign go  = (exc_valid || irq_take) && vec_known;
  assign bad = exc_valid && !vec_known;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect  <= 1'b0;
      cause_err <= 1'b0;
      priv_mode <= 1'b0;
      new_pc    <= '0;
      exc_addr  <= '0;
      err_code  <= '0;
    end else begin
      redirect  <= go;
      cause_err <= bad;
      if (go) begin
        new_pc    <= priv_base + PC_W'(vec_off);
        exc_addr  <= pc_in | PC_W'(priv_mode);
        err_code  <= sel_code;
        priv_mode <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
  import exc_dispatch_pkg::*;
#(
  parameter int PC_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic               redirect,
  input logic [PC_W-1:0]    exc_addr,
  input logic [PC_W-1:0]    pc_in,
  input logic [CODE_W-1:0]  err_code,
  input logic               priv_mode,
  input logic               cause_err
);
  a_r4_redirect_enters_priv: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> priv_mode);

  a_r4_priv_holds: assert property (@(posedge clk) disable iff (!rst_n)
    priv_mode |=> priv_mode);

  a_r8_no_irq_in_priv: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_mode && !exc_valid) |=> !redirect);

  a_r11_err_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    cause_err |-> !redirect);

  a_r11_err_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && int'(exc_cause) > int'(C_CALL)) |=> (cause_err && $stable(priv_mode)));

  a_r5_saved_mode_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && int'(exc_cause) <= int'(C_CALL)) |=>
      (exc_addr[0] == ($past(pc_in[0]) | $past(priv_mode))));

  a_r10_irq_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !$past(exc_valid)) |-> (err_code == '0));
endmodule

bind exc_dispatch exc_dispatch_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exc_valid (exc_valid),
  .exc_cause (exc_cause),
  .redirect  (redirect),
  .exc_addr  (exc_addr),
  .pc_in     (pc_in),
  .err_code  (err_code),
  .priv_mode (priv_mode),
  .cause_err (cause_err)
);

// File: tb/tb_exc_dispatch.sv
module tb_exc_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_cause = '0;
  logic [7:0]  exc_code = '0;
  logic [3:0]  irq_lines = '0;
  logic [2:0]  ipl = '0;
  logic [63:0] pc_in = '0;
  logic [63:0] priv_base = '0;
  logic        redirect, priv_mode, cause_err;
  logic [63:0] new_pc, exc_addr;
  logic [7:0]  err_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model state
  bit          m_priv;
  logic [63:0] m_pc, m_addr;
  logic [7:0]  m_code;

  always #10 clk = ~clk;

  exc_dispatch dut (
    .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_code(exc_code), .irq_lines(irq_lines), .ipl(ipl), .pc_in(pc_in),
    .priv_base(priv_base), .redirect(redirect), .new_pc(new_pc),
    .exc_addr(exc_addr), .err_code(err_code), .priv_mode(priv_mode),
    .cause_err(cause_err)
  );

  function automatic logic [63:0] f_offset(input logic [3:0] c, input logic [7:0] k);
    if (c <= 4'd9) return 64'(c) * 64'h80;
    if (k[7]) return 64'h2000 + 64'(k - 8'h80) * 64;
    return 64'h1000 + 64'(k) * 64;
  endfunction

  // Returns cause of the winning interrupt or 15 if none
  function automatic logic [3:0] f_irq(input logic [3:0] l, input logic [2:0] lv, input bit pm);
    if (pm) return 4'd15;
    if (l[3] && lv <= 6) return 4'd1;
    if (l[2] && lv <= 5) return 4'd2;
    if (l[1] && lv <= 4) return 4'd3;
    if (l[0] && lv <= 3) return 4'd4;
    return 4'd15;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; exc_valid = 1'b0; irq_lines = '0;
    @(negedge clk);
    rst_n = 1'b1;
    m_priv = 0; m_pc = '0; m_addr = '0; m_code = '0;
  endtask

  // Drive one cycle of stimulus and check the results one edge later.
  task automatic step(input bit v, input logic [3:0] c, input logic [7:0] k,
                      input logic [3:0] l, input logic [2:0] lv,
                      input logic [63:0] pc, input logic [63:0] base, input string req);
    logic [3:0] ic;
    bit go, bad;
    logic [3:0] sc;
    exc_valid = v; exc_cause = c; exc_code = k; irq_lines = l; ipl = lv;
    pc_in = pc; priv_base = base;
    ic  = f_irq(l, lv, m_priv);
    bad = v && c > 4'd10;
    go  = v ? !bad : (ic != 4'd15);
    sc  = v ? c : ic;
    if (go) begin
      m_pc   = base + f_offset(sc, v ? k : 8'h00);
      m_addr = pc | 64'(m_priv);
      m_code = v ? k : 8'h00;
      m_priv = 1;
    end
    @(negedge clk);
    exc_valid = 1'b0; irq_lines = '0;
    check(req, "redirect", 64'(redirect), 64'(go));
    check(req, "cause_err R11", 64'(cause_err), 64'(bad));
    check(req, "priv_mode R4", 64'(priv_mode), 64'(m_priv));
    check(req, "new_pc R4", new_pc, m_pc);
    check(req, "exc_addr R5", exc_addr, m_addr);
    check(req, "err_code R10", 64'(err_code), 64'(m_code));
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R12 reset state
    do_reset();
    check("R12", "redirect", 64'(redirect), 0);
    check("R12", "priv_mode", 64'(priv_mode), 0);
    check("R12", "cause_err", 64'(cause_err), 0);
    check("R12", "new_pc", new_pc, 0);
    check("R12", "exc_addr", exc_addr, 0);
    check("R12", "err_code", 64'(err_code), 0);

    // R1 every fixed vector
    for (int c = 0; c <= 9; c++) begin
      do_reset();
      step(1, 4'(c), 8'h11, 4'h0, 3'd0, 64'h1000_0040, 64'h8000_0000, "R1");
    end
    // R2 / R3 call boundaries
    do_reset(); step(1, 4'd10, 8'h00, 0, 0, 64'h44, 64'h10_0000, "R2");
    do_reset(); step(1, 4'd10, 8'h7F, 0, 0, 64'h44, 64'h10_0000, "R2");
    do_reset(); step(1, 4'd10, 8'h80, 0, 0, 64'h44, 64'h10_0000, "R3");
    do_reset(); step(1, 4'd10, 8'hFF, 0, 0, 64'h44, 64'h10_0000, "R3");
    // R5 nested exception saves mode bit
    do_reset();
    step(1, 4'd5, 8'h01, 0, 0, 64'h2000, 64'h9000, "R5");
    step(1, 4'd6, 8'h02, 0, 0, 64'h3000, 64'h9000, "R5");
    // R6 thresholds per line
    for (int i = 0; i < 4; i++) begin
      do_reset(); step(0, 0, 0, 4'(1 << i), 3'(3 + i), 64'h500, 64'hA000, "R6");
      do_reset(); step(0, 0, 0, 4'(1 << i), 3'(4 + i), 64'h500, 64'hA000, "R6");
    end
    // R7 priority with all lines up
    do_reset(); step(0, 0, 0, 4'hF, 3'd0, 64'h600, 64'hB000, "R7");
    do_reset(); step(0, 0, 0, 4'h7, 3'd2, 64'h600, 64'hB000, "R7");
    do_reset(); step(0, 0, 0, 4'h3, 3'd4, 64'h600, 64'hB000, "R7");
    // R8 blocked in privileged mode
    do_reset();
    step(1, 4'd8, 8'h05, 0, 0, 64'h700, 64'hC000, "R8");
    step(0, 0, 0, 4'hF, 3'd0, 64'h704, 64'hC000, "R8");
    // R9 exception beats interrupt
    do_reset(); step(1, 4'd7, 8'h09, 4'hF, 3'd0, 64'h800, 64'hD000, "R9");
    // R11 unknown cause keeps state, then R10 on a prior value
    do_reset();
    step(1, 4'd9, 8'h3C, 0, 0, 64'h900, 64'hE000, "R10");
    step(1, 4'd12, 8'h55, 4'hF, 0, 64'h904, 64'hF000, "R11");
    do_reset();
    step(1, 4'd15, 8'h55, 0, 0, 64'h904, 64'hF000, "R11");

    // Random mix
    for (int t = 0; t < 200; t++) begin
      int n;
      do_reset();
      n = 1 + ($urandom % 3);
      for (int s = 0; s < n; s++) begin
        step($urandom % 2, 4'($urandom), 8'($urandom), 4'($urandom), 3'($urandom),
             {$urandom, $urandom}, {$urandom, $urandom}, "R4");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule